// File: doc/BRIEF.md
# Sticky Write-Trap Control Unit

This block holds a 64-bit control word that decides which privileged system-register writes are diverted to the top exception level. Only code that runs at level 3 may read or write the control word, through a system-register access port. The word sits at one fixed encoding. Each of the low 22 bits guards one target register. A guard bit can be set by a write. Only reset clears it. Bits that belong to optional features are tied to zero when the feature is left out at build time.

Alongside the register, the block checks each incoming write request for a target register. The request carries a 5-bit target index, a flag that marks a paired (128-bit) write, a read/write flag and a valid strobe. The block answers in the same cycle with a trap strobe and a 6-bit exception class. The class depends on the width of the trapped write. The rest of the exception-entry path and the guarded target registers are outside this block.

Top module: `wtrap_ctl_unit`

## Requirements
- R1: After reset every control bit is 0: a read at level 3 returns zero and no request traps.
- R2: A level-3 write to the control word ORs the masked write data into it. Writing 0 to a set bit leaves it at 1 until the next reset.
- R3: Bits 63 to 22 of the control word always read as 0, whatever was written.
- R4: A feature-dependent bit reads as 0 and ignores writes when its feature parameter is 0. The dependencies are: bit 17 needs both the root PMU and granule-protection features; bit 16 needs the second control register; bit 14 needs permission indirection; bit 13 needs partitioning/monitoring; bit 12 needs memory encryption contexts; bits 10 and 4 need extended attributes; bits 8 and 7 need granule protection; bits 6 and 5 need shadow stacks.
- R5: An access that matches the control-word encoding from level 0, 1 or 2 raises the undefined flag in the same cycle, returns read data 0 and leaves the register unchanged.
- R6: The control word sits at encoding op0=3, op1=6, CRn=1, CRm=1, op2=5. A level-3 read there returns the register in the same cycle. An access at any other encoding raises no undefined flag, returns 0 and changes nothing.
- R7: A valid write request whose index (0 to 21) selects a set bit raises the trap in the same cycle with class 0x18 when the pair flag is 0. When there is no trap, the class output is 0.
- R8: A trapped paired write (pair flag 1) reports class 0x14.
- R9: Read requests never trap. Neither do requests whose index selects a clear bit, or an index of 22 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | System-register access strobe |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_el | input | 2 | Privilege level of the access |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_wdata | input | 64 | Write source operand |
| acc_rdata | output | 64 | Read data (0 unless a legal read hits) |
| acc_undef | output | 1 | Undefined-instruction flag |
| req_valid | input | 1 | Target-register request strobe |
| req_write | input | 1 | 1 = request is a write |
| req_pair | input | 1 | 1 = paired 128-bit write |
| req_idx | input | 5 | Index of the guarded target register |
| trap | output | 1 | Request must be trapped |
| trap_ec | output | 6 | Exception class of the trap |

## Verification
The bench builds the unit with the shadow-stack, extended-attribute and memory-encryption features switched off, and every other feature switched on. With that build, writes of all ones show bits 12, 10, 6, 5 and 4 staying at zero, while the neighbouring implemented bits set normally. With both the root PMU and granule-protection features on, bit 17 is reachable as a live guard. Trap requests over the full 5-bit index range then cover implemented bits, masked bits and indices above the guarded range, for both write widths.

// File: rtl/wtrap_pkg.sv
// Package: shared widths, exception classes and the access encoding
// of the write-trap control word.
package wtrap_pkg;

    localparam int CTL_W   = 64;   // control word width
    localparam int GUARD_N = 22;   // number of guard bits
    localparam int IDX_W   = 5;    // request index width
    localparam int EC_W    = 6;    // exception class width
    localparam int EL_W    = 2;    // privilege level width
    localparam logic [EL_W-1:0] EL_TOP = 2'd3;

    localparam logic [EC_W-1:0] EC_SINGLE = 6'h18;
    localparam logic [EC_W-1:0] EC_PAIR   = 6'h14;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sreg_enc_t;

    localparam sreg_enc_t CTL_ENC = '{op0: 2'b11, op1: 3'b110,
                                      crn: 4'b0001, crm: 4'b0001, op2: 3'b101};

    // Builds the mask of implemented guard bits from feature switches.
    function automatic logic [CTL_W-1:0] impl_mask(
        input bit root_pmu, input bit gran_prot, input bit ctrl2,
        input bit perm_ind, input bit part_mon, input bit mem_enc,
        input bit attr_ext, input bit shadow_stk);
        logic [CTL_W-1:0] m;
        m = '0;
        m[GUARD_N-1:0] = '1;
        m[17] = root_pmu & gran_prot;
        m[16] = ctrl2;
        m[14] = perm_ind;
        m[13] = part_mon;
        m[12] = mem_enc;
        m[10] = attr_ext;
        m[4]  = attr_ext;
        m[8]  = gran_prot;
        m[7]  = gran_prot;
        m[6]  = shadow_stk;
        m[5]  = shadow_stk;
        return m;
    endfunction

endpackage

// File: rtl/wtrap_acc_decode.sv
// Module: wtrap_acc_decode
// Decodes a system-register access against the control-word encoding
// and the privilege level. Assumes acc fields are stable while valid.
module wtrap_acc_decode
    import wtrap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [EL_W-1:0] acc_el,
    input  sreg_enc_t       acc_enc,
    output logic            hit_rd,
    output logic            hit_wr,
    output logic            undef
);
    logic enc_hit;
    logic el_ok;

    // Classify the access: legal read, legal write or undefined.
    always_comb begin
        enc_hit = acc_valid && (acc_enc == CTL_ENC);
        el_ok   = (acc_el == EL_TOP);
        hit_rd  = enc_hit && el_ok && !acc_write;
        hit_wr  = enc_hit && el_ok && acc_write;
        undef   = enc_hit && !el_ok;
    end

    // R5: undefined only from a lower privilege level, never with a legal hit
    assert_undef_lowpriv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (acc_el != EL_TOP) && !hit_rd && !hit_wr);

endmodule

// File: rtl/wtrap_sticky_reg.sv
// Module: wtrap_sticky_reg
// Holds the control word. Writes only set implemented bits; only the
// synchronous active-low reset clears them.
module wtrap_sticky_reg
    import wtrap_pkg::*;
#(
    parameter logic [CTL_W-1:0] IMPL_MASK = '0
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q
);
    // Accumulate set bits; reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en)
            ctl_q <= ctl_q | (wdata & IMPL_MASK);
    end

    // R2: a bit once set stays set until reset
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ctl_q & $past(ctl_q)) == $past(ctl_q)));

    // R4: an unimplemented bit never changes on a write
    assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctl_q & ~IMPL_MASK) == ($past(ctl_q) & ~IMPL_MASK)));

endmodule

// File: rtl/wtrap_trap_check.sv
// Module: wtrap_trap_check
// Combinational trap decision for a target-register request.
// Assumes the control word is already masked to implemented bits.
module wtrap_trap_check
    import wtrap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_pair,
    input  logic [IDX_W-1:0] req_idx,
    output logic             trap,
    output logic [EC_W-1:0]  trap_ec
);
    logic guard_set;

    // Look up the guard bit and choose the class from the write width.
    always_comb begin
        guard_set = (int'(req_idx) < GUARD_N) && ctl[req_idx];
        trap      = req_valid && req_write && guard_set;
        trap_ec   = trap ? (req_pair ? EC_PAIR : EC_SINGLE) : '0;
    end

    // R9: a trap needs a valid write request
    assert_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (req_valid && req_write));

    // R7: class output is 0 without a trap
    assert_ec_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |-> (trap_ec == '0));

endmodule

// File: rtl/wtrap_ctl_unit.sv
// Module: wtrap_ctl_unit (top)
// Sticky write-trap control word plus the same-cycle trap check.
// Assumes a synchronous active-low reset and one access per cycle.
module wtrap_ctl_unit
    import wtrap_pkg::*;
#(
    parameter bit HAS_ROOT_PMU   = 1'b1,
    parameter bit HAS_GRAN_PROT  = 1'b1,
    parameter bit HAS_CTRL2      = 1'b1,
    parameter bit HAS_PERM_IND   = 1'b1,
    parameter bit HAS_PART_MON   = 1'b1,
    parameter bit HAS_MEM_ENC    = 1'b1,
    parameter bit HAS_ATTR_EXT   = 1'b1,
    parameter bit HAS_SHADOW_STK = 1'b1
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  acc_el,
    input  logic [1:0]  acc_op0,
    input  logic [2:0]  acc_op1,
    input  logic [3:0]  acc_crn,
    input  logic [3:0]  acc_crm,
    input  logic [2:0]  acc_op2,
    input  logic [63:0] acc_wdata,
    output logic [63:0] acc_rdata,
    output logic        acc_undef,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_pair,
    input  logic [4:0]  req_idx,
    output logic        trap,
    output logic [5:0]  trap_ec
);
    localparam logic [CTL_W-1:0] IMPL_MASK = impl_mask(
        HAS_ROOT_PMU, HAS_GRAN_PROT, HAS_CTRL2, HAS_PERM_IND,
        HAS_PART_MON, HAS_MEM_ENC, HAS_ATTR_EXT, HAS_SHADOW_STK);

    sreg_enc_t        enc;
    logic             hit_rd;
    logic             hit_wr;
    logic [CTL_W-1:0] ctl_q;

    // Gather the encoding fields into one struct.
    always_comb begin
        enc = '{op0: acc_op0, op1: acc_op1, crn: acc_crn,
                crm: acc_crm, op2: acc_op2};
    end

    wtrap_acc_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_el    (acc_el),
        .acc_enc   (enc),
        .hit_rd    (hit_rd),
        .hit_wr    (hit_wr),
        .undef     (acc_undef)
    );

    wtrap_sticky_reg #(.IMPL_MASK(IMPL_MASK)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (hit_wr),
        .wdata (acc_wdata),
        .ctl_q (ctl_q)
    );

    wtrap_trap_check u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl_q),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_pair  (req_pair),
        .req_idx   (req_idx),
        .trap      (trap),
        .trap_ec   (trap_ec)
    );

    // Return the control word only on a legal read.
    always_comb begin
        acc_rdata = hit_rd ? ctl_q : '0;
    end

    // R5: a rejected access leaves the control word unchanged
    assert_lowpriv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_undef |=> $stable(ctl_q));

    // R3: reserved upper bits never read as 1
    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[CTL_W-1:GUARD_N] == '0);

endmodule

// File: tb/sim_wtrap_ctl_unit.sv
module sim_wtrap_ctl_unit;
    localparam int CLK_PERIOD = 10;
    localparam bit P_ROOT = 1, P_GRAN = 1, P_CTRL2 = 1, P_PERM = 1;
    localparam bit P_PART = 1, P_MENC = 0, P_ATTR = 0, P_SSTK = 0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write;
    logic [1:0]  acc_el, acc_op0;
    logic [2:0]  acc_op1, acc_op2;
    logic [3:0]  acc_crn, acc_crm;
    logic [63:0] acc_wdata, acc_rdata;
    logic        acc_undef;
    logic        req_valid, req_write, req_pair;
    logic [4:0]  req_idx;
    logic        trap;
    logic [5:0]  trap_ec;

    int errors = 0;
    int checks = 0;
    logic [63:0] exp_ctl;

    wtrap_ctl_unit #(
        .HAS_ROOT_PMU(P_ROOT), .HAS_GRAN_PROT(P_GRAN), .HAS_CTRL2(P_CTRL2),
        .HAS_PERM_IND(P_PERM), .HAS_PART_MON(P_PART), .HAS_MEM_ENC(P_MENC),
        .HAS_ATTR_EXT(P_ATTR), .HAS_SHADOW_STK(P_SSTK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_el(acc_el), .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn),
        .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_undef(acc_undef), .req_valid(req_valid),
        .req_write(req_write), .req_pair(req_pair), .req_idx(req_idx),
        .trap(trap), .trap_ec(trap_ec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Implemented bits as listed in R4 for this build.
    function automatic logic [63:0] bench_mask();
        logic [63:0] m = 64'h0000_0000_003F_FFFF;
        if (!(P_ROOT && P_GRAN)) m[17] = 1'b0;
        if (!P_CTRL2) m[16] = 1'b0;
        if (!P_PERM)  m[14] = 1'b0;
        if (!P_PART)  m[13] = 1'b0;
        if (!P_MENC)  m[12] = 1'b0;
        if (!P_ATTR) begin m[10] = 1'b0; m[4] = 1'b0; end
        if (!P_GRAN) begin m[8] = 1'b0; m[7] = 1'b0; end
        if (!P_SSTK) begin m[6] = 1'b0; m[5] = 1'b0; end
        return m;
    endfunction

    function automatic logic [5:0] bench_ec(input logic t, input logic pair);
        return t ? (pair ? 6'h14 : 6'h18) : 6'h00;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_write = 0; acc_el = 0; acc_wdata = '0;
        {acc_op0, acc_op1, acc_crn, acc_crm, acc_op2} = {2'b11, 3'b110, 4'd1, 4'd1, 3'b101};
        req_valid = 0; req_write = 0; req_pair = 0; req_idx = '0;
    endtask

    // One access cycle: drive after negedge, check outputs, commit at posedge.
    task automatic access(input string tag, input logic [1:0] el, input bit match,
                          input bit wr, input logic [63:0] data);
        logic exp_undef;
        logic [63:0] exp_rd;
        acc_valid = 1; acc_write = wr; acc_el = el; acc_wdata = data;
        {acc_op0, acc_op1, acc_crn, acc_crm, acc_op2} = {2'b11, 3'b110, 4'd1, 4'd1, 3'b101};
        if (!match) acc_op2 = 3'b100;
        #1;
        exp_undef = match && (el != 2'd3);
        exp_rd    = (match && el == 2'd3 && !wr) ? exp_ctl : 64'd0;
        chk({tag, " undef"}, {63'd0, acc_undef}, {63'd0, exp_undef});
        chk({tag, " rdata"}, acc_rdata, exp_rd);
        @(posedge clk);
        if (match && el == 2'd3 && wr) exp_ctl = exp_ctl | (data & bench_mask());
        @(negedge clk);
        idle();
    endtask

    task automatic read_back(input string tag);
        access(tag, 2'd3, 1'b1, 1'b0, 64'd0);
    endtask

    task automatic trap_req(input string tag, input logic [4:0] idx, input bit wr, input bit pair);
        logic exp_t;
        req_valid = 1; req_write = wr; req_pair = pair; req_idx = idx;
        #1;
        exp_t = wr && (idx < 5'd22) && exp_ctl[idx];
        chk({tag, " trap"}, {63'd0, trap}, {63'd0, exp_t});
        chk({tag, " ec"}, {58'd0, trap_ec}, {58'd0, bench_ec(exp_t, pair)});
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        exp_ctl = '0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        exp_ctl = '0;
        do_reset();

        // R1: reset state
        read_back("R1 reset read");
        trap_req("R1 reset idx0", 5'd0, 1, 0);
        trap_req("R1 reset idx21", 5'd21, 1, 1);

        // R5: lower privilege writes rejected
        for (int el = 0; el < 3; el++)
            access("R5 lowpriv write", el[1:0], 1'b1, 1'b1, '1);
        access("R5 lowpriv read", 2'd1, 1'b1, 1'b0, '0);
        read_back("R5 unchanged");

        // R6: non-matching encoding ignored
        access("R6 other enc", 2'd3, 1'b0, 1'b1, '1);
        read_back("R6 unchanged");

        // R2: set then attempt to clear
        access("R2 set", 2'd3, 1'b1, 1'b1, 64'h0000_0000_0002_0003);
        read_back("R2 after set");
        access("R2 clear try", 2'd3, 1'b1, 1'b1, 64'd0);
        read_back("R2 sticky");

        // R7 / R8 / R9 trap checks
        trap_req("R7 single", 5'd0, 1, 0);
        trap_req("R8 pair", 5'd1, 1, 1);
        trap_req("R7 bit17", 5'd17, 1, 0);
        trap_req("R9 read req", 5'd0, 0, 0);
        trap_req("R9 clear bit", 5'd2, 1, 0);

        // R3 / R4: write all ones
        access("R4 all ones", 2'd3, 1'b1, 1'b1, '1);
        read_back("R3 R4 masked read");
        trap_req("R4 masked bit12", 5'd12, 1, 0);
        trap_req("R4 masked bit5", 5'd5, 1, 1);
        trap_req("R8 pair bit21", 5'd21, 1, 1);
        trap_req("R9 idx 22", 5'd22, 1, 0);
        trap_req("R9 idx 31", 5'd31, 1, 1);

        // Random phase (R2 R5 R6 R7 R8 R9)
        do_reset();
        read_back("R1 second reset");
        for (int i = 0; i < 400; i++) begin
            logic [63:0] d;
            d = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) d = d | 64'hFFFF_FFFF_FFC0_0000;
            access("R2 R5 R6 random access", 2'($urandom_range(0, 3)),
                   ($urandom_range(0, 4) != 0), 1'($urandom), d);
            trap_req("R7 R8 R9 random req", 5'($urandom), 1'($urandom), 1'($urandom));
        end
        read_back("R2 R3 final read");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule